// File: doc/BRIEF.md
# Framed SPI Transfer Master over a JTAG Chain

This block runs on the host side of a JTAG scan chain. It carries one SPI transaction through a one-bit user data register inside a remote device. It generates TCK from the system clock through a run-time divider. It walks the TAP controller from Run-Test/Idle into Shift-DR and back again. Within a single DR scan it shifts a framed bit stream. The stream starts with zero padding, one zero per bypassed device ahead of the target. A single 1 follows as the start marker. Then comes a 32-bit count header, sent high bit first, that holds the SPI cycle count minus one. The SPI payload is next, and the scan ends with flush cycles that carry the last returned bits past the remaining devices.

On the user side, a transaction is started with a bit count and the two bypass counts. Payload bytes are fed in on a valid/ready stream, and returned bytes leave on a second valid/ready stream. The block discards the TDO samples taken before the first payload response. It keeps exactly as many bits as were sent and packs them high bit first into bytes. When either stream is not ready, the block holds TCK still instead of dropping or inventing bits.

Top module: `jtagSpiFramer`

## Requirements
- R1: After reset, busy, tck, tms, tdi, rxValid and txReady are all 0.
- R2: Each transfer drives TMS, one value per TCK cycle, as 1,0,0. It then holds TMS at 0 for every shift bit except the last, which has TMS at 1. It closes with 1,0, so the TAP passes Select-DR, Capture-DR, Shift-DR, Exit1-DR and Update-DR and ends in Run-Test/Idle.
- R3: TDI and TMS change only while TCK is low. Each TCK half period lasts clkDiv+1 system clock cycles unless a stream stalls it.
- R4: For pre upstream and post downstream bypass devices, the shifted stream starts with pre zeros and then one 1. The 32-bit value bitCount-1 follows, high bit first. A target that counts this field down to zero therefore runs exactly bitCount SPI cycles.
- R5: The payload follows the header directly. Its bits are taken from txData bytes high bit first, and the unused low bits of a final partial byte are never sent. TDI is 0 in the flush cycles. A scan shifts exactly 2*pre+post+34+bitCount bits, assuming a target delay of one TCK cycle.
- R6: The first 2*pre+post+34 TDO samples of the scan are dropped. The remaining bitCount samples are packed high bit first into ceil(bitCount/8) bytes on rxData, and a final partial byte is left-aligned with zeros in its low bits.
- R7: While rxValid is high and rxReady is low, rxData stays stable. If another byte would complete, TCK stops until the byte is taken.
- R8: When a payload bit needs a new byte and txValid is low, TCK stops and TMS, TDI and the scan position hold. txReady is high only in a cycle that takes a byte with txValid high.
- R9: busy rises on an accepted start and falls only after the TAP is back in Run-Test/Idle with TCK low. A start while busy, or a start with bitCount 0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| bitCount | input | 16 | Number of SPI cycles, at least 1 |
| preBypass | input | 6 | Bypassed devices between host TDI and target |
| postBypass | input | 6 | Bypassed devices between target and host TDO |
| clkDiv | input | 8 | TCK half period minus one, in system cycles |
| busy | output | 1 | Transfer in progress |
| txData | input | 8 | Payload byte, sent high bit first |
| txValid | input | 1 | txData holds a byte |
| txReady | output | 1 | Byte taken this cycle |
| rxData | output | 8 | Returned byte, high bit first |
| rxValid | output | 1 | rxData holds a byte |
| rxReady | input | 1 | Consumer takes rxData |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data toward the chain |
| tdo | input | 1 | JTAG data from the chain |

## Verification
The bench attaches a behavioural chain to the pins: upstream and downstream bypass registers that Capture-DR clears, a TAP state tracker, and a target that waits for the marker, loads the count, and echoes each MOSI bit inverted. The corner cases are a one-bit payload, a count that is not a multiple of eight, and unequal bypass counts on the two sides. Under these, an off-by-one drop count would return shifted bytes. A wrong header would make the target run the wrong number of cycles. Padding in the wrong place would make the target miss the marker. Two stall scenarios starve the payload stream and refuse returned bytes. A design that kept clocking in either case would lose or invent bits, and the bench also confirms that a second start mid-scan leaves the scan length unchanged.

// File: rtl/jfsPkg.sv
package jfsPkg;

  // Role of the bit placed on TDI in a given TCK cycle.
  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_PAD,
    KIND_MARK,
    KIND_HDR,
    KIND_PAY,
    KIND_FLUSH
  } bitKind_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;       // accepted start: reset datapath state
    logic     present;    // TCK falling now: drive next TDI bit
    bitKind_e kind;       // role of the bit about to be presented
    logic     sample;     // TCK rising now: capture TDO
    logic     sampleWin;  // current cycle lies in the capture window
    logic     lastCap;    // current cycle is the final shift bit
  } ctlStrobe_t;

endpackage

// File: rtl/jfsCtrl.sv
module jfsCtrl
  import jfsPkg::*;
#(
  parameter int NBITS_W = 16,
  parameter int BYP_W   = 6,
  parameter int DIV_W   = 8,
  parameter int HDR_W   = 32,
  parameter int TGT_LAT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NBITS_W-1:0] bitCount,
  input  logic [BYP_W-1:0]   preBypass,
  input  logic [BYP_W-1:0]   postBypass,
  input  logic [DIV_W-1:0]   clkDiv,
  input  logic               txStarve,
  input  logic               rxBlock,
  output logic               tck,
  output logic               tms,
  output logic               busy,
  output ctlStrobe_t         strb
);

  localparam int CYC_W = NBITS_W + BYP_W + $clog2(HDR_W) + 3;
  localparam logic [CYC_W-1:0] ENTRY_LEN = CYC_W'(3);
  localparam logic [CYC_W-1:0] HDR_LEN   = CYC_W'(HDR_W);
  localparam logic [CYC_W-1:0] LAT_LEN   = CYC_W'(TGT_LAT);
  localparam logic [CYC_W-1:0] ONE       = CYC_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_PARK} ctlState_e;

  ctlState_e        st;
  logic [DIV_W-1:0] divCnt, divLim;
  logic             tckR, tmsR;
  logic [CYC_W-1:0] cycIdx, nextIdx, lastIdx;
  logic [CYC_W-1:0] markIdx, payBeg, flushBeg, capBeg, lastShift;
  logic [CYC_W-1:0] markIdxN, payBegN, flushBegN, capBegN, lastShiftN;
  logic             startOk, halfTick, riseGo, fallGo, parkGo, inWin;
  bitKind_e         nextKind;

  // Frame boundaries for the requested transfer, in TCK cycle indices.
  always_comb begin
    markIdxN   = ENTRY_LEN + CYC_W'(preBypass);
    payBegN    = markIdxN + ONE + HDR_LEN;
    flushBegN  = payBegN + CYC_W'(bitCount);
    lastShiftN = flushBegN + CYC_W'(preBypass) + LAT_LEN
               + CYC_W'(postBypass) - ONE;
    capBegN    = lastShiftN - CYC_W'(bitCount) + ONE;
  end

  assign startOk  = (st == S_IDLE) && start && (bitCount != '0);
  assign nextIdx  = cycIdx + ONE;
  assign lastIdx  = lastShift + CYC_W'(2);
  assign halfTick = (st != S_IDLE) && (divCnt == divLim);
  assign riseGo   = (st == S_RUN) && halfTick && !tckR && !rxBlock;
  assign fallGo   = (st == S_RUN) && halfTick && tckR && !txStarve;
  assign parkGo   = (st == S_PARK) && halfTick;
  assign inWin    = (st == S_RUN) && !tckR
                 && (cycIdx >= capBeg) && (cycIdx <= lastShift);

  always_comb begin
    if (nextIdx < ENTRY_LEN || nextIdx > lastShift) nextKind = KIND_NONE;
    else if (nextIdx < markIdx)                     nextKind = KIND_PAD;
    else if (nextIdx == markIdx)                    nextKind = KIND_MARK;
    else if (nextIdx < payBeg)                      nextKind = KIND_HDR;
    else if (nextIdx < flushBeg)                    nextKind = KIND_PAY;
    else                                            nextKind = KIND_FLUSH;
  end

  always_comb begin
    strb.load      = startOk;
    strb.present   = fallGo;
    strb.kind      = nextKind;
    strb.sample    = riseGo && inWin;
    strb.sampleWin = inWin;
    strb.lastCap   = (cycIdx == lastShift);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= S_IDLE;
      divCnt    <= '0;
      divLim    <= '0;
      tckR      <= 1'b0;
      tmsR      <= 1'b0;
      cycIdx    <= '0;
      markIdx   <= '0;
      payBeg    <= '0;
      flushBeg  <= '0;
      capBeg    <= '0;
      lastShift <= '0;
    end else begin
      if (halfTick) begin
        if (riseGo || fallGo || parkGo) divCnt <= '0;
      end else if (st != S_IDLE) begin
        divCnt <= divCnt + DIV_W'(1);
      end
      unique case (st)
        S_IDLE: if (startOk) begin
          st        <= S_RUN;
          tmsR      <= 1'b1;           // toward Select-DR
          tckR      <= 1'b0;
          cycIdx    <= '0;
          divCnt    <= '0;
          divLim    <= clkDiv;
          markIdx   <= markIdxN;
          payBeg    <= payBegN;
          flushBeg  <= flushBegN;
          capBeg    <= capBegN;
          lastShift <= lastShiftN;
        end
        S_RUN: begin
          if (riseGo) begin
            tckR <= 1'b1;
            if (cycIdx == lastIdx) st <= S_PARK;
          end
          if (fallGo) begin
            tckR   <= 1'b0;
            cycIdx <= nextIdx;
            tmsR   <= (nextIdx == lastShift) || (nextIdx == lastShift + ONE);
          end
        end
        S_PARK: if (parkGo) begin
          tckR <= 1'b0;
          tmsR <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tck  = tckR;
  assign tms  = tmsR;
  assign busy = (st != S_IDLE);

  AST_SAMPLE_IN_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> (tmsR == (cycIdx == lastShift)));  // R2
  AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tckR);  // R9
  AST_STALL_HOLDS_TCK: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tckR && txStarve) |=> tckR);  // R8

endmodule

// File: rtl/jfsData.sv
module jfsData
  import jfsPkg::*;
#(
  parameter int NBITS_W = 16,
  parameter int HDR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [NBITS_W-1:0] bitCount,
  input  logic [7:0]         txData,
  input  logic               txValid,
  output logic               txReady,
  input  logic               tdo,
  output logic [7:0]         rxData,
  output logic               rxValid,
  input  logic               rxReady,
  output logic               tdi,
  output logic               txStarve,
  output logic               rxBlock
);

  logic [HDR_W-1:0] hdrR;
  logic [7:0]       txByte, rxSh, capByte, packed8;
  logic [3:0]       bitsLeft;
  logic [2:0]       rxCnt;
  logic             tdiR, rxValidR, needByte, complete;
  logic [7:0]       rxDataR;

  assign needByte = (strb.kind == KIND_PAY) && (bitsLeft == 4'd0);
  assign txStarve = needByte && !txValid;
  assign txReady  = strb.present && needByte && txValid;
  assign capByte  = {rxSh[6:0], tdo};
  assign complete = (rxCnt == 3'd7) || strb.lastCap;
  assign packed8  = capByte << (3'd7 - rxCnt);
  assign rxBlock  = strb.sampleWin && complete && rxValidR && !rxReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrR     <= '0;
      txByte   <= '0;
      bitsLeft <= '0;
      tdiR     <= 1'b0;
      rxSh     <= '0;
      rxCnt    <= '0;
      rxDataR  <= '0;
      rxValidR <= 1'b0;
    end else begin
      if (strb.load) begin
        hdrR     <= HDR_W'(bitCount) - HDR_W'(1);
        bitsLeft <= '0;
        tdiR     <= 1'b0;
        rxSh     <= '0;
        rxCnt    <= '0;
      end
      if (strb.present) begin
        unique case (strb.kind)
          KIND_MARK: tdiR <= 1'b1;
          KIND_HDR: begin
            tdiR <= hdrR[HDR_W-1];
            hdrR <= hdrR << 1;
          end
          KIND_PAY: begin
            if (needByte) begin
              tdiR     <= txData[7];
              txByte   <= {txData[6:0], 1'b0};
              bitsLeft <= 4'd7;
            end else begin
              tdiR     <= txByte[7];
              txByte   <= txByte << 1;
              bitsLeft <= bitsLeft - 4'd1;
            end
          end
          default: tdiR <= 1'b0;
        endcase
      end
      if (rxValidR && rxReady) rxValidR <= 1'b0;
      if (strb.sample) begin
        rxSh  <= capByte;
        rxCnt <= rxCnt + 3'd1;
        if (complete) begin
          rxDataR  <= packed8;
          rxValidR <= 1'b1;
          rxCnt    <= '0;
        end
      end
    end
  end

  assign tdi     = tdiR;
  assign rxData  = rxDataR;
  assign rxValid = rxValidR;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValidR && !rxReady) |=> (rxValidR && $stable(rxDataR)));  // R7
  AST_TX_TAKE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txValid);  // R8
  AST_NO_SAMPLE_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample |-> !rxBlock);  // R7

endmodule

// File: rtl/jtagSpiFramer.sv
module jtagSpiFramer
  import jfsPkg::*;
#(
  parameter int NBITS_W = 16,
  parameter int BYP_W   = 6,
  parameter int DIV_W   = 8,
  parameter int HDR_W   = 32,
  parameter int TGT_LAT = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [NBITS_W-1:0] bitCount,
  input  logic [BYP_W-1:0]   preBypass,
  input  logic [BYP_W-1:0]   postBypass,
  input  logic [DIV_W-1:0]   clkDiv,
  output logic               busy,
  input  logic [7:0]         txData,
  input  logic               txValid,
  output logic               txReady,
  output logic [7:0]         rxData,
  output logic               rxValid,
  input  logic               rxReady,
  output logic               tck,
  output logic               tms,
  output logic               tdi,
  input  logic               tdo
);

  ctlStrobe_t strb;
  logic       txStarve, rxBlock;

  jfsCtrl #(
    .NBITS_W(NBITS_W), .BYP_W(BYP_W), .DIV_W(DIV_W),
    .HDR_W(HDR_W), .TGT_LAT(TGT_LAT)
  ) ctl_i (
    .clk(clk), .rstN(rstN), .start(start), .bitCount(bitCount),
    .preBypass(preBypass), .postBypass(postBypass), .clkDiv(clkDiv),
    .txStarve(txStarve), .rxBlock(rxBlock),
    .tck(tck), .tms(tms), .busy(busy), .strb(strb)
  );

  jfsData #(.NBITS_W(NBITS_W), .HDR_W(HDR_W)) dat_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bitCount(bitCount),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .tdo(tdo), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .tdi(tdi), .txStarve(txStarve), .rxBlock(rxBlock)
  );

  AST_PINS_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tdi) && $stable(tms)));  // R3
  AST_TX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> busy);  // R8

endmodule

// File: tb/jtagSpiFramer_tb_top.sv
`timescale 1ns/1ps
module jtagSpiFramer_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] bitCount = '0;
  logic [5:0]  preBypass = '0, postBypass = '0;
  logic [7:0]  clkDiv = '0;
  logic        busy, txReady, rxValid, tck, tms, tdi, tdo;
  logic [7:0]  txData, rxData;
  logic        txValid;
  logic        rxReady;

  int  checks = 0, fails = 0;
  bit  allDone = 0;

  // user-side sources and sinks
  logic [7:0] txMem [0:63];
  logic [7:0] rxMem [0:63];
  int  txPtr = 0, rxPtr = 0, txBytes = 0;
  bit  txGate = 1, rxEn = 1;
  assign txValid = txGate && (txPtr < txBytes);
  assign txData  = txMem[txPtr[5:0]];
  assign rxReady = rxEn;
  always @(posedge clk) begin
    if (txValid && txReady) txPtr <= txPtr + 1;
    if (rxValid && rxReady) begin
      rxMem[rxPtr[5:0]] <= rxData;
      rxPtr <= rxPtr + 1;
    end
  end

  jtagSpiFramer dut_i (
    .clk(clk), .rstN(rstN), .start(start), .bitCount(bitCount),
    .preBypass(preBypass), .postBypass(postBypass), .clkDiv(clkDiv),
    .busy(busy), .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  // behavioural chain: bypass devices, TAP tracker, target with echo flash
  int   mPre = 0, mPost = 0;
  int   tapSt = 0, tgt = 0, hcnt = 0;
  int   tmsCnt = 0, shiftCnt = 0, csCycles = 0, headCnt = 0;
  logic [31:0] lenR = '0;
  logic [15:0] preCh = '0, postCh = '0;
  logic misoR = 1'b0;
  logic tmsLog  [0:1023];
  logic mosiLog [0:1023];
  logic tIn;
  assign tdo = (mPost == 0) ? misoR : postCh[mPost-1];
  assign tIn = (mPre == 0) ? tdi : preCh[mPre-1];

  always @(posedge tck) begin
    tmsLog[tmsCnt] <= tms;
    tmsCnt <= tmsCnt + 1;
    case (tapSt)
      0: tapSt <= tms ? 1 : 0;
      1: tapSt <= tms ? 7 : 2;
      2: begin
        tapSt  <= tms ? 7 : 3;
        preCh  <= '0;
        postCh <= '0;
        misoR  <= 1'b0;
      end
      3: begin
        tapSt    <= tms ? 4 : 3;
        shiftCnt <= shiftCnt + 1;
        preCh    <= {preCh[14:0], tdi};
        postCh   <= {postCh[14:0], misoR};
        case (tgt)
          0: begin
            misoR <= 1'b0;
            if (tIn) begin tgt <= 1; hcnt <= 31; headCnt <= headCnt + 1; end
          end
          1: begin
            misoR <= 1'b0;
            lenR  <= {lenR[30:0], tIn};
            if (hcnt == 0) tgt <= 2; else hcnt <= hcnt - 1;
          end
          default: begin
            mosiLog[csCycles] <= tIn;
            csCycles <= csCycles + 1;
            misoR    <= ~tIn;
            if (lenR == 0) tgt <= 0; else lenR <= lenR - 1;
          end
        endcase
      end
      4: tapSt <= tms ? 5 : 7;
      5: tapSt <= tms ? 1 : 0;
      default: tapSt <= 7;
    endcase
  end

  // pin monitor, sampled away from the clock edge
  int   toggles = 0, edgeViol = 0, hiRun = 0, firstHi = 0;
  bit   gotHi = 0;
  logic prevTck = 1'b0, prevTdi = 1'b0, prevTms = 1'b0;
  always @(negedge clk) begin
    if (tck != prevTck) toggles <= toggles + 1;
    if (tck && prevTck && (tdi != prevTdi || tms != prevTms)) edgeViol <= edgeViol + 1;
    if (tck) hiRun <= hiRun + 1;
    else if (prevTck) begin
      if (!gotHi) begin firstHi <= hiRun; gotHi <= 1; end
      hiRun <= 0;
    end
    prevTck <= tck; prevTdi <= tdi; prevTms <= tms;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // one full transfer with optional stalls, followed by all checks
  task automatic runXfer(input int pre, input int post, input int n, input int div,
                         input bit starve, input bit rxHold, input bit extraStart,
                         input int seed);
    int L, nBytes, tg, sc;
    logic [7:0] held;
    bit tmsOk, mosiOk;
    @(negedge clk);
    preBypass = 6'(pre); postBypass = 6'(post); bitCount = 16'(n); clkDiv = 8'(div);
    mPre = pre; mPost = post;
    nBytes = (n + 7) / 8;
    for (int k = 0; k < 64; k++) txMem[k] = 8'(k * 37 + seed);
    txPtr = 0; rxPtr = 0; txBytes = nBytes;
    tapSt = 0; tgt = 0; tmsCnt = 0; shiftCnt = 0; csCycles = 0; headCnt = 0;
    gotHi = 0; hiRun = 0;
    txGate = !starve; rxEn = !rxHold;
    L = 2 * pre + post + 34 + n;
    pulseStart();
    check(busy == 1'b1, "R9", "busy after start", busy, 1);
    if (extraStart) begin
      repeat (40) @(negedge clk);
      pulseStart();
    end
    if (starve) begin
      repeat (400) @(negedge clk);
      tg = toggles; sc = shiftCnt;
      repeat (100) @(negedge clk);
      check(toggles == tg, "R8", "tck toggles while starved", toggles - tg, 0);
      check(sc == pre + 33, "R8", "stall point in shift bits", sc, pre + 33);
      check(txPtr == 0, "R8", "bytes taken while starved", txPtr, 0);
      txGate = 1;
    end
    if (rxHold) begin
      repeat (600) @(negedge clk);
      held = rxData; tg = toggles;
      check(rxValid == 1'b1, "R7", "rxValid held", rxValid, 1);
      repeat (100) @(negedge clk);
      check(rxData == held, "R7", "rxData stable", rxData, held);
      check(toggles == tg, "R7", "tck toggles while blocked", toggles - tg, 0);
      rxEn = 1;
    end
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    tmsOk = (tmsCnt == L + 5);
    for (int i = 0; i < L + 5 && i < 1024; i++) begin
      logic e;
      e = (i == 0) || (i == L + 2) || (i == L + 3);
      if (tmsLog[i] !== e) tmsOk = 0;
    end
    check(tmsOk, "R2", "tms sequence length", tmsCnt, L + 5);
    check(tapSt == 0, "R2", "tap final state", tapSt, 0);
    check(shiftCnt == L, "R5", "shift bits", shiftCnt, L);
    check(headCnt == 1, "R4", "markers seen", headCnt, 1);
    check(csCycles == n, "R4", "spi cycles", csCycles, n);
    mosiOk = 1;
    for (int j = 0; j < n; j++)
      if (mosiLog[j] !== txMem[j / 8][7 - (j % 8)]) mosiOk = 0;
    check(mosiOk, "R5", "mosi payload match", mosiOk, 1);
    check(rxPtr == nBytes, "R6", "rx byte count", rxPtr, nBytes);
    for (int k = 0; k < nBytes; k++) begin
      logic [7:0] exp;
      exp = ~txMem[k];
      if (k == nBytes - 1 && (n % 8) != 0) exp = exp & (8'hFF << (8 - n % 8));
      check(rxMem[k] == exp, "R6", "rx byte", rxMem[k], exp);
    end
    check(edgeViol == 0, "R3", "tdi/tms changes while tck high", edgeViol, 0);
    check(firstHi == div + 1, "R3", "tck high half period", firstHi, div + 1);
    check(busy == 1'b0 && tck == 1'b0, "R9", "busy/tck after end", busy, 0);
  endtask

  task automatic testReset();
    check(busy == 0, "R1", "busy", busy, 0);
    check(tck == 0 && tms == 0 && tdi == 0, "R1", "jtag pins", {tck, tms, tdi}, 0);
    check(rxValid == 0 && txReady == 0, "R1", "stream flags", {rxValid, txReady}, 0);
  endtask

  task automatic testBasic();     runXfer(0, 0, 8, 0, 0, 0, 0, 3);  endtask
  task automatic testPartial();   runXfer(2, 3, 20, 1, 0, 0, 0, 11); endtask
  task automatic testOneBit();    runXfer(1, 0, 1, 2, 0, 0, 0, 5);  endtask
  task automatic testStarve();    runXfer(1, 2, 24, 0, 1, 0, 0, 7); endtask
  task automatic testRxHold();    runXfer(0, 0, 24, 0, 0, 1, 0, 9); endtask
  task automatic testStartBusy(); runXfer(3, 1, 13, 0, 0, 0, 1, 1); endtask

  task automatic testZeroCount();
    int tg;
    @(negedge clk) bitCount = 16'd0;
    tg = toggles;
    pulseStart();
    repeat (20) @(negedge clk);
    check(busy == 0 && toggles == tg, "R9", "start with zero count", busy, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testBasic();
    testPartial();
    testOneBit();
    testStarve();
    testRxHold();
    testStartBusy();
    testZeroCount();
    allDone = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!allDone) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", busy, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule